// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether the conditional branches in a fetch group are taken, and it learns from the outcomes that come back when those branches resolve. A fetch group has two instruction slots. Slot 0 is the word at the fetch address and slot 1 is the next word. Each slot gets two dynamic opinions. One comes from a per-branch local history and the table it indexes. The other comes from a global outcome history hashed with the branch address. A chooser table, indexed by address, decides which opinion to trust. A software hint on a slot can replace the dynamic answer with a fixed direction.

The predictions are combinational: they are valid in the same cycle as the fetch inputs. The global history moves ahead speculatively with every branch that is predicted. Along with each prediction, the block outputs the state the front end must carry with the branch: the local opinion, the global opinion and the history snapshot the slot used. When the branch resolves, this state comes back on the resolve port together with the real outcome. The block then flags a misprediction in that same cycle, so fetch can be redirected and younger work discarded. It also repairs the history and trains the tables.

Top module: `tourney_dir_pred`

## Requirements
- R1: After reset, every direction and chooser counter holds 2'b01 (weakly not-taken, weakly prefer local), and all local histories and the global history are zero. The first fetch therefore predicts not-taken in both slots, and both history snapshots read 0.
- R2: Each slot has a 2-bit hint, with slot s at fetch_hint[2s+1:2s]. When the upper bit is 1, the prediction is the lower bit (1 = taken), whatever the tables hold. When the upper bit is 0, the dynamic prediction is used.
- R3: Without a hint, the word index is fetch_pc[ADDR_W-1:2] for slot 0 and that index plus 1 for slot 1. The local opinion is the top bit of the local counter selected by the local history at the low LHT_IDX_W index bits. The global opinion is the top bit of the global counter at the slot's snapshot XOR the low GHR_W index bits. The chooser counter at the low CHS_IDX_W index bits selects global when its top bit is 1, and local otherwise. pred_taken is 0 when fetch_vld is low or the slot holds no branch.
- R4: When slot 0 holds a branch predicted taken, slot 1 predicts not-taken, and its branch does not enter the global history.
- R5: On a valid fetch, each live branch shifts its prediction into the global history at bit 0, slot 0 first. Slot 0's snapshot is the history before the group. Slot 1's snapshot includes slot 0's shift.
- R6: res_mispredict is high in the same cycle as res_vld when res_taken differs from res_pred.
- R7: On a misprediction, the next global history is {res_ghr[GHR_W-2:0], res_taken}. This takes precedence over any fetch shift in that cycle.
- R8: A resolve without res_static moves the local counter, selected by that branch's current local history, one step toward the outcome. The outcome is then shifted into that local history.
- R9: A resolve without res_static moves the global counter at res_ghr XOR the resolved word index one step toward the outcome.
- R10: The chooser is trained only when res_local differs from res_global. It steps toward global when res_global equals the outcome, and toward local otherwise.
- R11: A resolve with res_static set changes no table and no local history.
- R12: All counters saturate at 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 1 | Fetch group valid |
| fetch_pc | input | ADDR_W | Address of slot 0 |
| fetch_br | input | 2 | Slot holds a conditional branch |
| fetch_hint | input | 4 | Per-slot hint {static, direction} |
| pred_taken | output | 2 | Final prediction per slot |
| pred_local | output | 2 | Local opinion per slot |
| pred_global | output | 2 | Global opinion per slot |
| pred_ghr | output | 2*GHR_W | History snapshot per slot, slot s at [s*GHR_W +: GHR_W] |
| res_vld | input | 1 | Resolve valid |
| res_pc | input | ADDR_W | Resolved branch address |
| res_taken | input | 1 | Actual outcome |
| res_pred | input | 1 | Prediction that was made |
| res_local | input | 1 | Local opinion at prediction time |
| res_global | input | 1 | Global opinion at prediction time |
| res_static | input | 1 | Branch was hinted; do not train |
| res_ghr | input | GHR_W | History snapshot at prediction time |
| res_mispredict | output | 1 | Outcome differs from prediction |

## Verification
The predictions, the opinions, the snapshots and res_mispredict are all due in the cycle whose inputs cause them. Changes to the history and the tables appear at the outputs from the cycle after the clock edge. The bench drives each cycle on the falling edge and samples one time unit later, before the rising edge. It advances its own counter-and-history model only after that rising edge. Each comparison therefore sees the state left by the previous cycle.

// File: rtl/tdp_pkg.sv
// Shared types and counter arithmetic for the tournament direction predictor.
// Assumes every predictor entry is a 2-bit saturating counter.
package tdp_pkg;
    typedef logic [1:0] ctr2_t;

    // Weakly not-taken / weakly prefer-local.
    localparam ctr2_t CTR_INIT = 2'b01;

    // One saturating step toward the given direction.
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        if (up) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction
endpackage

// File: rtl/tdp_ctr_table.sv
// Table of 2-bit saturating counters with NRD combinational direction reads
// and one read-modify-write training port. Reads see the value before training
// in the same cycle.
module tdp_ctr_table
    import tdp_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output logic [NRD-1:0]            rd_dir,
    input  logic                      upd_en,
    input  logic [IDX_W-1:0]          upd_idx,
    input  logic                      upd_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    // Reset all counters, then train one entry per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (upd_en) begin
            mem[upd_idx] <= ctr_step(mem[upd_idx], upd_up);
        end
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            // Direction is the counter's upper bit.
            assign rd_dir[r] = mem[rd_idx[r]][1];
        end
    endgenerate
endmodule

// File: rtl/tdp_local_hist.sv
// Per-branch outcome histories indexed by address bits. NRD combinational
// reads; one update port shifts a resolved outcome into bit 0.
module tdp_local_hist #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 6,
    parameter int NRD    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][HIST_W-1:0] rd_hist,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           upd_idx,
    input  logic                       upd_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    // Clear all histories, then shift one resolved outcome per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (upd_en) begin
            hist[upd_idx] <= {hist[upd_idx][HIST_W-2:0], upd_bit};
        end
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            // Plain indexed read.
            assign rd_hist[r] = hist[rd_idx[r]];
        end
    endgenerate
endmodule

// File: rtl/tdp_ghr.sv
// Speculative global history. Gives the snapshot each slot sees, shifts in
// predicted directions, and on repair reloads from a carried snapshot plus the
// real outcome (repair wins over a same-cycle shift).
module tdp_ghr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s0_en,
    input  logic         s0_bit,
    input  logic         s1_en,
    input  logic         s1_bit,
    input  logic         fix_en,
    input  logic [W-2:0] fix_keep,
    input  logic         fix_bit,
    output logic [W-1:0] snap0,
    output logic [W-1:0] snap1
);
    logic [W-1:0] ghr;
    logic [W-1:0] ghr_nxt;

    // Snapshots per slot and the history after the whole group.
    always_comb begin
        snap0   = ghr;
        snap1   = s0_en ? {ghr[W-2:0], s0_bit} : ghr;
        ghr_nxt = s1_en ? {snap1[W-2:0], s1_bit} : snap1;
    end

    // Register the history, with repair taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)      ghr <= '0;
        else if (fix_en) ghr <= {fix_keep, fix_bit};
        else             ghr <= ghr_nxt;
    end
endmodule

// File: rtl/tourney_dir_pred.sv
// Two-slot tournament direction predictor: local-history table, global
// history table (history XOR address), and an address-indexed chooser.
// Assumes 4-byte instruction words, slot 1 at fetch_pc + 4, and resolves
// arriving in any order with their prediction-time state.
module tourney_dir_pred
    import tdp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GHR_W     = 10,
    parameter int LHT_IDX_W = 6,
    parameter int LHIST_W   = 6,
    parameter int CHS_IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_vld,
    input  logic [ADDR_W-1:0]    fetch_pc,
    input  logic [1:0]           fetch_br,
    input  logic [3:0]           fetch_hint,
    output logic [1:0]           pred_taken,
    output logic [1:0]           pred_local,
    output logic [1:0]           pred_global,
    output logic [2*GHR_W-1:0]   pred_ghr,
    input  logic                 res_vld,
    input  logic [ADDR_W-1:0]    res_pc,
    input  logic                 res_taken,
    input  logic                 res_pred,
    input  logic                 res_local,
    input  logic                 res_global,
    input  logic                 res_static,
    input  logic [GHR_W-1:0]     res_ghr,
    output logic                 res_mispredict
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int NSLOT  = 2;

    logic [NSLOT-1:0][WORD_W-1:0]    slot_word;
    logic [WORD_W-1:0]               res_word;
    logic [NSLOT:0][LHT_IDX_W-1:0]   lht_idx;
    logic [NSLOT:0][LHIST_W-1:0]     lht_val;
    logic [NSLOT-1:0][LHIST_W-1:0]   lpht_idx;
    logic [NSLOT-1:0][GHR_W-1:0]     gpht_idx;
    logic [NSLOT-1:0][CHS_IDX_W-1:0] chs_idx;
    logic [NSLOT-1:0][GHR_W-1:0]     snap;
    logic [NSLOT-1:0]                l_dir, g_dir, c_dir, dir, live;
    logic                            train_en;
    logic                            unused_bits;

    // Word index of each slot and of the resolving branch.
    always_comb begin
        slot_word[0] = fetch_pc[ADDR_W-1:2];
        slot_word[1] = fetch_pc[ADDR_W-1:2] + WORD_W'(1);
        res_word     = res_pc[ADDR_W-1:2];
    end

    assign unused_bits = ^{fetch_pc[1:0], res_pc[1:0], slot_word, res_word};

    // Per-slot table indices and final direction choice.
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            assign lht_idx[s]  = slot_word[s][LHT_IDX_W-1:0];
            assign lpht_idx[s] = lht_val[s];
            assign gpht_idx[s] = snap[s] ^ slot_word[s][GHR_W-1:0];
            assign chs_idx[s]  = slot_word[s][CHS_IDX_W-1:0];
            assign dir[s]      = fetch_hint[2*s+1] ? fetch_hint[2*s]
                                                   : (c_dir[s] ? g_dir[s] : l_dir[s]);
        end
    endgenerate

    assign lht_idx[NSLOT] = res_word[LHT_IDX_W-1:0];
    assign train_en       = res_vld & ~res_static;

    // Which slots carry a prediction; a taken slot 0 hides slot 1.
    always_comb begin
        live[0] = fetch_vld & fetch_br[0];
        live[1] = fetch_vld & fetch_br[1] & ~(fetch_br[0] & dir[0]);
    end

    tdp_local_hist #(
        .IDX_W (LHT_IDX_W),
        .HIST_W(LHIST_W),
        .NRD   (NSLOT + 1)
    ) u_lht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lht_idx),
        .rd_hist(lht_val),
        .upd_en (train_en),
        .upd_idx(lht_idx[NSLOT]),
        .upd_bit(res_taken)
    );

    tdp_ctr_table #(
        .IDX_W(LHIST_W),
        .NRD  (NSLOT)
    ) u_lpht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lpht_idx),
        .rd_dir (l_dir),
        .upd_en (train_en),
        .upd_idx(lht_val[NSLOT]),
        .upd_up (res_taken)
    );

    tdp_ctr_table #(
        .IDX_W(GHR_W),
        .NRD  (NSLOT)
    ) u_gpht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (gpht_idx),
        .rd_dir (g_dir),
        .upd_en (train_en),
        .upd_idx(res_ghr ^ res_word[GHR_W-1:0]),
        .upd_up (res_taken)
    );

    tdp_ctr_table #(
        .IDX_W(CHS_IDX_W),
        .NRD  (NSLOT)
    ) u_chs (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (chs_idx),
        .rd_dir (c_dir),
        .upd_en (train_en & (res_local ^ res_global)),
        .upd_idx(res_word[CHS_IDX_W-1:0]),
        .upd_up (res_global ~^ res_taken)
    );

    tdp_ghr #(
        .W(GHR_W)
    ) u_ghr (
        .clk     (clk),
        .rst_n   (rst_n),
        .s0_en   (live[0]),
        .s0_bit  (dir[0]),
        .s1_en   (live[1]),
        .s1_bit  (dir[1]),
        .fix_en  (res_mispredict),
        .fix_keep(res_ghr[GHR_W-2:0]),
        .fix_bit (res_taken),
        .snap0   (snap[0]),
        .snap1   (snap[1])
    );

    // Outputs handed to the front end.
    always_comb begin
        pred_taken     = live & dir;
        pred_local     = l_dir;
        pred_global    = g_dir;
        pred_ghr       = {snap[1], snap[0]};
        res_mispredict = res_vld & (res_taken ^ res_pred);
    end
endmodule

// File: rtl/tdp_checker.sv
// Port-level properties of the tournament direction predictor; bound to the top.
module tdp_checker #(
    parameter int GHR_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_vld,
    input logic [1:0]         fetch_br,
    input logic [3:0]         fetch_hint,
    input logic [1:0]         pred_taken,
    input logic [2*GHR_W-1:0] pred_ghr,
    input logic               res_vld,
    input logic               res_taken,
    input logic [GHR_W-1:0]   res_ghr,
    input logic               res_mispredict
);
    p_hint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_br[0] && fetch_hint[1]) |-> (pred_taken[0] == fetch_hint[0]));

    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |-> (pred_taken == 2'b00));

    p_suppress_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_br[0] && pred_taken[0]) |-> !pred_taken[1]);

    p_snap1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_br[0]) |->
        (pred_ghr[2*GHR_W-1:GHR_W] == {pred_ghr[GHR_W-2:0], pred_taken[0]}));

    p_spec_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_br == 2'b01 && !res_mispredict) |=>
        (pred_ghr[GHR_W-1:0] == {$past(pred_ghr[GHR_W-2:0]), $past(pred_taken[0])}));

    p_mis_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_mispredict |-> res_vld);

    p_repair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_mispredict |=>
        (pred_ghr[GHR_W-1:0] == {$past(res_ghr[GHR_W-2:0]), $past(res_taken)}));
endmodule

bind tourney_dir_pred tdp_checker #(.GHR_W(GHR_W)) u_tdp_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_vld     (fetch_vld),
    .fetch_br      (fetch_br),
    .fetch_hint    (fetch_hint),
    .pred_taken    (pred_taken),
    .pred_ghr      (pred_ghr),
    .res_vld       (res_vld),
    .res_taken     (res_taken),
    .res_ghr       (res_ghr),
    .res_mispredict(res_mispredict)
);

// File: tb/tourney_dir_pred_test.sv
// Directed bench with an independent counter/history model built from the requirements.
module tourney_dir_pred_test;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_vld = 1'b0;
    logic [31:0]     fetch_pc = '0;
    logic [1:0]      fetch_br = '0;
    logic [3:0]      fetch_hint = '0;
    logic [1:0]      pred_taken, pred_local, pred_global;
    logic [2*GW-1:0] pred_ghr;
    logic            res_vld = 1'b0, res_taken = 1'b0, res_pred = 1'b0;
    logic            res_local = 1'b0, res_global = 1'b0, res_static = 1'b0;
    logic [31:0]     res_pc = '0;
    logic [GW-1:0]   res_ghr = '0;
    logic            res_mispredict;

    tourney_dir_pred uut (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .fetch_br(fetch_br), .fetch_hint(fetch_hint), .pred_taken(pred_taken),
        .pred_local(pred_local), .pred_global(pred_global), .pred_ghr(pred_ghr),
        .res_vld(res_vld), .res_pc(res_pc), .res_taken(res_taken), .res_pred(res_pred),
        .res_local(res_local), .res_global(res_global), .res_static(res_static),
        .res_ghr(res_ghr), .res_mispredict(res_mispredict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;

    // Model state.
    logic [5:0]    m_lht  [64];
    logic [1:0]    m_lpht [64];
    logic [1:0]    m_gpht [1024];
    logic [1:0]    m_ch   [256];
    logic [GW-1:0] m_ghr;

    // Last sampled outputs.
    logic [1:0]      s_pt, s_loc, s_glob;
    logic [2*GW-1:0] s_ghr;
    logic            s_mis;

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin m_lht[i] = '0; m_lpht[i] = 2'b01; end
        for (int i = 0; i < 1024; i++) m_gpht[i] = 2'b01;
        for (int i = 0; i < 256; i++) m_ch[i] = 2'b01;
        m_ghr = '0;
    endtask

    // One cycle: drive, compare against the model, clock, advance the model.
    task automatic step(string tag, logic fv, logic [31:0] pc, logic [1:0] br, logic [3:0] hint,
                        logic rv, logic [31:0] rpc, logic rt, logic rp, logic rl, logic rg,
                        logic rs, logic [GW-1:0] rgh);
        logic [29:0] w0, w1, rw;
        logic [GW-1:0] sn0, sn1;
        logic l0, l1, g0, g1, d0, d1, a0, a1, mis;
        logic [5:0] h;
        @(negedge clk);
        fetch_vld = fv; fetch_pc = pc; fetch_br = br; fetch_hint = hint;
        res_vld = rv; res_pc = rpc; res_taken = rt; res_pred = rp;
        res_local = rl; res_global = rg; res_static = rs; res_ghr = rgh;
        #1;
        w0 = pc[31:2]; w1 = w0 + 30'd1; rw = rpc[31:2];
        sn0 = m_ghr;
        l0 = m_lpht[m_lht[w0[5:0]]][1];
        g0 = m_gpht[sn0 ^ w0[9:0]][1];
        d0 = hint[1] ? hint[0] : (m_ch[w0[7:0]][1] ? g0 : l0);
        a0 = fv & br[0];
        sn1 = a0 ? {sn0[GW-2:0], d0} : sn0;
        l1 = m_lpht[m_lht[w1[5:0]]][1];
        g1 = m_gpht[sn1 ^ w1[9:0]][1];
        d1 = hint[3] ? hint[2] : (m_ch[w1[7:0]][1] ? g1 : l1);
        a1 = fv & br[1] & ~(br[0] & d0);
        mis = rv & (rt != rp);
        s_pt = pred_taken; s_loc = pred_local; s_glob = pred_global;
        s_ghr = pred_ghr; s_mis = res_mispredict;
        check(tag, "pred_taken", 32'(pred_taken), 32'({a1 & d1, a0 & d0}));
        check(tag, "pred_local", 32'(pred_local), 32'({l1, l0}));
        check(tag, "pred_global", 32'(pred_global), 32'({g1, g0}));
        check(tag, "pred_ghr", 32'(pred_ghr), 32'({sn1, sn0}));
        check(tag, "res_mispredict", 32'(res_mispredict), 32'(mis));
        @(posedge clk);
        if (rv && !rs) begin
            h = m_lht[rw[5:0]];
            m_lpht[h] = sat(m_lpht[h], rt);
            m_lht[rw[5:0]] = {h[4:0], rt};
            m_gpht[rgh ^ rw[9:0]] = sat(m_gpht[rgh ^ rw[9:0]], rt);
            if (rl != rg) m_ch[rw[7:0]] = sat(m_ch[rw[7:0]], rg == rt);
        end
        if (mis)     m_ghr = {rgh[GW-2:0], rt};
        else if (a1) m_ghr = {sn1[GW-2:0], d1};
        else         m_ghr = sn1;
    endtask

    task automatic fetch(string tag, logic [31:0] pc, logic [1:0] br, logic [3:0] hint);
        step(tag, 1'b1, pc, br, hint, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic resolve(string tag, logic [31:0] pc, logic t, logic p, logic l, logic g,
                           logic s, logic [GW-1:0] gh);
        step(tag, 1'b0, '0, 2'b00, 4'h0, 1'b1, pc, t, p, l, g, s, gh);
    endtask

    task automatic t_reset();
        fetch("R1", 32'h40, 2'b11, 4'h0);
        check("R1", "reset pred", 32'(s_pt), 32'h0);
        check("R1", "reset snapshots", 32'(s_ghr), 32'h0);
    endtask

    task automatic t_hint();
        fetch("R2", 32'h80, 2'b11, 4'b1110);
        check("R2", "hinted slots", 32'(s_pt), 32'h2);
        fetch("R4", 32'h80, 2'b11, 4'b1111);
        check("R4", "slot1 suppressed", 32'(s_pt), 32'h1);
        fetch("R5", 32'h90, 2'b00, 4'h0);
        check("R5", "history after hints", 32'(s_ghr[GW-1:0]), 32'h3);
    endtask

    task automatic t_local();
        for (int i = 0; i < 9; i++) resolve("R8", 32'h100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        fetch("R8", 32'h100, 2'b01, 4'h0);
        check("R8", "local learned taken", 32'(s_loc[0]), 32'h1);
        check("R8", "local chosen", 32'(s_pt[0]), 32'h1);
        resolve("R8", 32'h100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        fetch("R8", 32'h100, 2'b11, 4'h0);
    endtask

    task automatic t_sat();
        for (int i = 0; i < 5; i++) resolve("R12", 32'h500, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        resolve("R12", 32'h500, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        fetch("R12", 32'h500, 2'b01, 4'h0);
        check("R12", "global saturated then one step", 32'(s_glob[0]), 32'h1);
        check("R9", "global index from snapshot", 32'(s_ghr[GW-1:0]), 32'h0);
    endtask

    task automatic t_chooser();
        fetch("R10", 32'h3C4, 2'b01, 4'h0);
        resolve("R10", 32'h3C4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        resolve("R10", 32'h3C4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        fetch("R10", 32'h3C4, 2'b01, 4'h0);
        check("R10", "chooser picks global", 32'(s_pt[0]), 32'(s_glob[0]));
        resolve("R10", 32'h3C4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0);
        resolve("R10", 32'h3C4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        resolve("R10", 32'h3C4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        fetch("R10", 32'h3C4, 2'b01, 4'h0);
        check("R10", "chooser back to local", 32'(s_pt[0]), 32'(s_loc[0]));
    endtask

    task automatic t_mispredict();
        step("R6", 1'b1, 32'h600, 2'b11, 4'h0, 1'b1, 32'h600, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'h2AA);
        check("R6", "mispredict flagged", 32'(s_mis), 32'h1);
        step("R7", 1'b1, 32'h604, 2'b00, 4'h0, 1'b1, 32'h604, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h155);
        check("R7", "history repaired", 32'(s_ghr[GW-1:0]), 32'h155);
        check("R6", "correct prediction not flagged", 32'(s_mis), 32'h0);
    endtask

    task automatic t_static();
        logic l_before, g_before;
        fetch("R11", 32'h700, 2'b01, 4'h0);
        l_before = s_loc[0];
        resolve("R11", 32'h700, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        fetch("R11", 32'h700, 2'b01, 4'h0);
        l_before = s_loc[0]; g_before = s_glob[0];
        for (int i = 0; i < 4; i++)
            resolve("R11", 32'h700, ~l_before, ~l_before, 1'b1, 1'b0, 1'b1, s_ghr[GW-1:0]);
        step("R11", 1'b1, 32'h700, 2'b00, 4'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R11", "local untouched", 32'(s_loc[0]), 32'(l_before));
        check("R11", "global untouched", 32'(s_glob[0]), 32'(g_before));
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            step("R3", lf[0] | lf[1], 32'h1000 | {24'h0, lf[5:0], 2'b00}, lf[7:6],
                 (lf[9:8] == 2'b11) ? lf[13:10] : 4'h0,
                 lf[14], 32'h1000 | {24'h0, lf[20:15], 2'b00}, lf[21], lf[22], lf[23], lf[24],
                 lf[25] & lf[26], lf[31:22]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hint();
        t_local();
        t_sat();
        t_chooser();
        t_mispredict();
        t_static();
        t_sweep();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule